// File: doc/BRIEF.md
# Dual-Thread Transactional Conflict Detector

This block watches the memory traffic of two hardware threads running speculative transactions and decides when one of them must be rolled back. Each thread owns two hashed bit vectors held in flip-flops. One records the locations the transaction has loaded, and the other records the locations it has stored. The hash is plain bit selection: a parameterised field of the address picks one signature bit.

Every access is tested in the cycle it arrives against the other thread's vectors. A store is tested against both of the other thread's sets. A load is tested only against the other thread's write set. Two accesses in the same cycle are also tested against each other. The thread that must abort sees a one-cycle pulse on its abort output one clock later, and its vectors are wiped on that same edge. A commit or abort request from the pipeline empties a thread's vectors in one cycle.

Aliasing can produce false conflicts, and they are accepted. A true overlap is never missed.

Top module: `tm_conflict_det`

## Requirements
- R1: A load issued with the valid and active flags set sets the bit selected by address bits [SEL_LSB+IDX_W-1:SEL_LSB] in that thread's read vector. A later store to that index by the other thread aborts the other thread.
- R2: A store issued with the valid and active flags set sets the selected bit in that thread's write vector. A later load or store to that index by the other thread aborts the other thread.
- R3: A load never conflicts with the other thread's read vector. Load against load at the same index gives no abort.
- R4: Any two addresses whose selected bits match are treated as the same location, whatever their other bits, and a store or load conflict between them is reported.
- R5: `abort_req[t]` is registered. It is high for exactly the one cycle after the cycle of thread t's conflicting access, and low otherwise.
- R6: An access made while that thread's `tx_active` is low sets no bit and raises no abort.
- R7: `tx_end[t]` high for one cycle empties both vectors of thread t at that edge. Later accesses by the other thread then see no conflict with thread t's earlier accesses.
- R8: When both threads access the same index in the same cycle and at least one of them stores, thread 1 is aborted and thread 0 is not. Thread 0's access is still recorded.
- R9: An aborted thread's vectors are emptied on the edge that registers its abort, and its conflicting access is not recorded.
- R10: When `tx_end[t]` and an access by thread t fall in the same cycle, the clear wins and the access leaves no bit set.
- R11: After reset both aborts are low and all vectors are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 2 | Per-thread flag: a transaction is running |
| tx_end | input | 2 | Per-thread commit/abort: clear that thread's vectors |
| acc_valid | input | 2 | Per-thread memory access strobe |
| acc_store | input | 2 | Per-thread access kind: 1 = store, 0 = load |
| acc_addr0 | input | ADDR_W | Thread 0 access address |
| acc_addr1 | input | ADDR_W | Thread 1 access address |
| abort_req | output | 2 | Per-thread abort pulse, one cycle after the conflicting access |

## Verification
The vectors are not visible at the ports. A stuck, missing or stale signature bit therefore shows only when the other thread touches the same index. It then appears as a missing or extra abort pulse exactly one clock after that probing access. The bench sweeps every pair of indices and every load/store combination, both with one access following the other and with both in the same cycle. Each wrong bit or wrong priority decision is thus exposed on the first probe that selects it. Directed sequences probe the vectors after clears, aborts and inactive accesses. This shows whether a wipe or a suppressed update really happened.

// File: rtl/tmsig_pkg.sv
package tmsig_pkg;
    localparam int NTHR = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_op_e;

    function automatic acc_op_e decode_op(input logic valid, input logic active,
                                          input logic store);
        if (!valid || !active) return ACC_NONE;
        return store ? ACC_STORE : ACC_LOAD;
    endfunction
endpackage

// File: rtl/sig_hash.sv
module sig_hash #(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 4,
    parameter int SEL_LSB = 2,
    localparam int SIG_W  = 1 << IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [SIG_W-1:0]  hot
);
    // bit selection: a contiguous address field names the signature bit
    assign idx = addr[SEL_LSB +: IDX_W];

    for (genvar b = 0; b < SIG_W; b++) begin : g_dec
        assign hot[b] = (idx == IDX_W'(b));
    end

    logic unused_addr_bits;
    assign unused_addr_bits = ^addr;
endmodule

// File: rtl/sig_track.sv
module sig_track #(
    parameter int SIG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set_rd,
    input  logic             set_wr,
    input  logic [SIG_W-1:0] hot,
    output logic [SIG_W-1:0] rd_q,
    output logic [SIG_W-1:0] wr_q
);
    typedef struct packed {
        logic [SIG_W-1:0] rd;
        logic [SIG_W-1:0] wr;
    } sig_t;

    sig_t sig_d, sig_q;

    always_comb begin
        sig_d = sig_q;
        if (clr) begin
            sig_d.rd = '0;
            sig_d.wr = '0;
        end else begin
            if (set_rd) sig_d.rd = sig_q.rd | hot;
            if (set_wr) sig_d.wr = sig_q.wr | hot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    assign rd_q = sig_q.rd;
    assign wr_q = sig_q.wr;

    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (rd_q == '0 && wr_q == '0));

    p_one_new_read_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_q & ~$past(rd_q)) <= 1);

    p_one_new_write_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_q & ~$past(wr_q)) <= 1);
endmodule

// File: rtl/conflict_chk.sv
module conflict_chk
    import tmsig_pkg::*;
#(
    parameter int SIG_W = 16
) (
    input  acc_op_e          op0,
    input  acc_op_e          op1,
    input  logic [SIG_W-1:0] hot0,
    input  logic [SIG_W-1:0] hot1,
    input  logic [SIG_W-1:0] rd0,
    input  logic [SIG_W-1:0] wr0,
    input  logic [SIG_W-1:0] rd1,
    input  logic [SIG_W-1:0] wr1,
    output logic [1:0]       abort_now
);
    logic hit0, hit1, pair;

    function automatic logic probe(input acc_op_e op, input logic [SIG_W-1:0] hot,
                                   input logic [SIG_W-1:0] rd_o,
                                   input logic [SIG_W-1:0] wr_o);
        case (op)
            ACC_STORE: return |(hot & (rd_o | wr_o));
            ACC_LOAD:  return |(hot & wr_o);
            default:   return 1'b0;
        endcase
    endfunction

    always_comb begin
        hit0 = probe(op0, hot0, rd1, wr1);
        hit1 = probe(op1, hot1, rd0, wr0);
        pair = (op0 != ACC_NONE) && (op1 != ACC_NONE) && (|(hot0 & hot1))
               && ((op0 == ACC_STORE) || (op1 == ACC_STORE));
        // same-cycle clash: thread 0 has fixed priority
        abort_now[0] = hit0;
        abort_now[1] = hit1 | pair;
    end
endmodule

// File: rtl/tm_conflict_det.sv
module tm_conflict_det
    import tmsig_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 4,
    parameter int SEL_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tx_active,
    input  logic [1:0]        tx_end,
    input  logic [1:0]        acc_valid,
    input  logic [1:0]        acc_store,
    input  logic [ADDR_W-1:0] acc_addr0,
    input  logic [ADDR_W-1:0] acc_addr1,
    output logic [1:0]        abort_req
);
    localparam int SIG_W = 1 << IDX_W;

    typedef struct packed {
        logic [NTHR-1:0] abort;
    } state_t;

    acc_op_e          op   [NTHR];
    logic [IDX_W-1:0] idx  [NTHR];
    logic [SIG_W-1:0] hot  [NTHR];
    logic [SIG_W-1:0] rd_s [NTHR];
    logic [SIG_W-1:0] wr_s [NTHR];
    logic [1:0]       abort_now;
    state_t           st_d, st_q;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        sig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL_LSB(SEL_LSB)) u_hash (
            .addr (t == 0 ? acc_addr0 : acc_addr1),
            .idx  (idx[t]),
            .hot  (hot[t])
        );

        assign op[t] = decode_op(acc_valid[t], tx_active[t], acc_store[t]);

        sig_track #(.SIG_W(SIG_W)) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (tx_end[t] | abort_now[t]),
            .set_rd (op[t] == ACC_LOAD),
            .set_wr (op[t] == ACC_STORE),
            .hot    (hot[t]),
            .rd_q   (rd_s[t]),
            .wr_q   (wr_s[t])
        );

        p_abort_needs_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
            abort_req[t] |-> $past(acc_valid[t] && tx_active[t]));

        p_inactive_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!tx_active[t]) |-> !abort_req[t]);
    end

    conflict_chk #(.SIG_W(SIG_W)) u_chk (
        .op0       (op[0]),
        .op1       (op[1]),
        .hot0      (hot[0]),
        .hot1      (hot[1]),
        .rd0       (rd_s[0]),
        .wr0       (wr_s[0]),
        .rd1       (rd_s[1]),
        .wr1       (wr_s[1]),
        .abort_now (abort_now)
    );

    always_comb begin
        st_d       = st_q;
        st_d.abort = abort_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign abort_req = st_q.abort;

    p_pair_aborts_thread1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op[0] != ACC_NONE && op[1] != ACC_NONE && idx[0] == idx[1]
              && (op[0] == ACC_STORE || op[1] == ACC_STORE)) |-> abort_req[1]);

    p_loads_spare_read_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op[0] == ACC_LOAD && wr_s[1] == '0) |-> !abort_req[0]);
endmodule

// File: tb/sim_tm_conflict_det.sv
`timescale 1ns/1ps
module sim_tm_conflict_det;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tx_active = '0, tx_end = '0, acc_valid = '0, acc_store = '0;
    logic [31:0] acc_addr0 = '0, acc_addr1 = '0;
    logic [1:0]  abort_req;
    int          n_cmp = 0, n_bad = 0, n_cyc = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tm_conflict_det u0 (
        .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .tx_end(tx_end),
        .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_addr0(acc_addr0), .acc_addr1(acc_addr1), .abort_req(abort_req)
    );

    function automatic logic [31:0] mk_addr(input int upper, input int idx);
        return {upper[25:0], idx[3:0], 2'b10};
    endfunction

    task automatic check(input string tag, input logic [1:0] exp);
        n_cmp++;
        if (abort_req !== exp) begin
            n_bad++;
            $display("FAIL %s: abort_req=%b expected %b", tag, abort_req, exp);
        end
    endtask

    // apply one cycle of stimulus; returns at the following negedge
    task automatic step(input logic [1:0] v, input logic [1:0] s, input logic [1:0] a,
                        input logic [1:0] e, input logic [31:0] a0, input logic [31:0] a1);
        acc_valid = v; acc_store = s; tx_active = a; tx_end = e;
        acc_addr0 = a0; acc_addr1 = a1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        step(2'b00, 2'b00, 2'b11, 2'b00, '0, '0);
    endtask

    task automatic wipe();
        step(2'b00, 2'b00, 2'b11, 2'b11, '0, '0);
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc >= 150000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: cycles=%0d expected completion", n_cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset", 2'b00);
        // R11 empty after reset: stores by both threads find nothing
        step(2'b01, 2'b01, 2'b11, 2'b00, mk_addr(1, 3), '0);
        step(2'b10, 2'b10, 2'b11, 2'b00, '0, mk_addr(2, 5));
        check("R11 vectors empty", 2'b00);
        wipe();

        // exhaustive sequential sweep: thread 1 first, thread 0 probes (R1 R2 R3 R4)
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                for (int k = 0; k < 4; k++) begin
                    logic s0, s1;
                    s0 = k[0]; s1 = k[1];
                    step(2'b10, {s1, 1'b0}, 2'b11, 2'b00, '0, mk_addr(i + 100, j));
                    step(2'b01, {1'b0, s0}, 2'b11, 2'b00, mk_addr(j + 7, i), '0);
                    check("R1 R2 R3 R4 sequential",
                          {1'b0, (i == j) && (s0 || s1)});
                    wipe();
                end

        // exhaustive same-cycle sweep (R8)
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                for (int k = 0; k < 4; k++) begin
                    logic s0, s1;
                    s0 = k[0]; s1 = k[1];
                    step(2'b11, {s1, s0}, 2'b11, 2'b00, mk_addr(i, i), mk_addr(j + 9, j));
                    check("R8 same-cycle priority", {(i == j) && (s0 || s1), 1'b0});
                    wipe();
                end

        // R5 pulse lasts one cycle
        step(2'b01, 2'b01, 2'b11, 2'b00, mk_addr(0, 8), '0);
        step(2'b10, 2'b00, 2'b11, 2'b00, '0, mk_addr(4, 8));
        check("R5 pulse high", 2'b10);
        idle();
        check("R5 pulse low after one cycle", 2'b00);
        wipe();

        // R6 inactive store leaves no bit; inactive store raises no abort
        step(2'b01, 2'b01, 2'b10, 2'b00, mk_addr(0, 5), '0);
        step(2'b10, 2'b00, 2'b11, 2'b00, '0, mk_addr(0, 5));
        check("R6 inactive store not recorded", 2'b00);
        step(2'b01, 2'b01, 2'b10, 2'b00, mk_addr(0, 5), '0);
        check("R6 inactive store vs read set", 2'b00);
        wipe();

        // R7 commit clears
        step(2'b01, 2'b01, 2'b11, 2'b00, mk_addr(0, 3), '0);
        step(2'b00, 2'b00, 2'b11, 2'b01, '0, '0);
        step(2'b10, 2'b00, 2'b11, 2'b00, '0, mk_addr(0, 3));
        check("R7 cleared write set", 2'b00);
        wipe();

        // R8 loser's set wiped, winner's access kept
        step(2'b10, 2'b00, 2'b11, 2'b00, '0, mk_addr(0, 12));
        step(2'b11, 2'b01, 2'b11, 2'b00, mk_addr(0, 9), mk_addr(1, 9));
        check("R8 thread 1 aborted", 2'b10);
        step(2'b01, 2'b01, 2'b11, 2'b00, mk_addr(0, 12), '0);
        check("R8 loser read set wiped", 2'b00);
        step(2'b10, 2'b00, 2'b11, 2'b00, '0, mk_addr(3, 9));
        check("R8 winner store recorded", 2'b10);
        wipe();

        // R9 aborted thread wiped, conflicting access not recorded
        step(2'b01, 2'b00, 2'b11, 2'b00, mk_addr(0, 2), '0);
        step(2'b10, 2'b00, 2'b11, 2'b00, '0, mk_addr(0, 4));
        step(2'b10, 2'b10, 2'b11, 2'b00, '0, mk_addr(0, 2));
        check("R9 store hits read set", 2'b10);
        step(2'b01, 2'b01, 2'b11, 2'b00, mk_addr(0, 4), '0);
        check("R9 aborted read set wiped", 2'b00);
        step(2'b01, 2'b00, 2'b11, 2'b00, mk_addr(0, 2), '0);
        check("R9 aborting store not recorded", 2'b00);
        wipe();

        // R10 clear beats same-cycle access
        step(2'b01, 2'b01, 2'b11, 2'b01, mk_addr(0, 7), '0);
        step(2'b10, 2'b00, 2'b11, 2'b00, '0, mk_addr(0, 7));
        check("R10 clear wins over store", 2'b00);
        wipe();

        // R4 alias with very different upper bits
        step(2'b10, 2'b10, 2'b11, 2'b00, '0, mk_addr(26'h3ffffff, 11));
        step(2'b01, 2'b00, 2'b11, 2'b00, mk_addr(0, 11), '0);
        check("R4 alias reported", 2'b01);
        wipe();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule